// File: doc/BRIEF.md
# Prefetch Candidate Filter with Trigger Recovery

This block sits between a prefetch-candidate generator and the memory request port. It keeps a shadow of the cache tags, each line with a bit recording that the line came from a prefetch. A candidate whose line the shadow already holds is dropped. Every candidate that is sent out is recorded in a tracking table together with the program-counter field and the address of the access that triggered it.

Fills from memory return with their address alone. The block looks each fill up in the tracking table and attaches the saved trigger information, so that later training logic can credit the right trigger. A fill that matches nothing is passed on with its trigger flag low.

Both tables are direct-mapped. The index is address bits [15:6], the line bits just above the 6-bit line offset. The shadow tag is address bits [21:16]. Demand accesses probe the shadow, and the block reports whether they landed on a line that was prefetched and not yet used.

Top module: `pf_filter_tracker`

## Requirements
- R1: After reset, reqValid, fillOutValid and demPfHit are low, and both tables are empty, so the first candidate is issued.
- R2: A candidate that is neither a shadow duplicate nor blocked by a busy tracking slot gives reqValid high on the next cycle, with reqAddr equal to candAddr.
- R3: A candidate is dropped, and reqValid stays low on the next cycle, when the shadow entry at index addr[15:6] is valid and its tag equals addr[21:16].
- R4: A candidate is dropped when the tracking slot at index addr[15:6] is occupied at the start of the cycle. This holds even when a fill frees that slot in the same cycle.
- R5: A fill whose line address addr[47:6] equals that of the valid tracking entry at its index gives, on the next cycle, fillOutValid=1, fillHasTrig=1, fillOutAddr=fillAddr, and the stored trigger PC and trigger address. The tracking entry is freed.
- R6: A fill that matches no tracking entry gives, on the next cycle, fillOutValid=1 and fillHasTrig=0, with the trigger PC and trigger address at zero.
- R7: A demand access whose shadow entry is valid, tag-matching and marked prefetched gives demPfHit=1 on the next cycle and clears the mark. A repeated demand to that line, or a demand to an absent line, gives demPfHit=0.
- R8: An issue writes the shadow entry with the new tag and sets its prefetch mark, replacing any older tag at that index. When an issue and a demand hit the same index in the same cycle, the issue's write wins.
- R9: A fill leaves the shadow unchanged, so a candidate for a line that has just been filled is still dropped as a duplicate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| candValid | input | 1 | Prefetch candidate present |
| candAddr | input | 48 | Candidate byte address |
| candTrigPc | input | 6 | Trigger program-counter field of the candidate |
| candTrigAddr | input | 48 | Address of the triggering access |
| demValid | input | 1 | Demand access present |
| demAddr | input | 48 | Demand access address |
| fillValid | input | 1 | Fill returning from memory |
| fillAddr | input | 48 | Fill address |
| reqValid | output | 1 | Prefetch request issued |
| reqAddr | output | 48 | Prefetch request address |
| fillOutValid | output | 1 | Fill forwarded |
| fillOutAddr | output | 48 | Forwarded fill address |
| fillHasTrig | output | 1 | Trigger information recovered |
| fillTrigPc | output | 6 | Recovered trigger PC field |
| fillTrigAddr | output | 48 | Recovered trigger address |
| demPfHit | output | 1 | Demand hit a prefetched, unused line |

## Verification
The hardest states to reach from the ports are collisions at a single index. Examples are a fill freeing a slot in the same cycle that a candidate asks for it, a demand and an issue writing the same shadow entry together, and a fill that agrees with a stored entry in index and tag but not in its upper address bits. The random stimulus therefore confines addresses to a few indexes, tags and upper-bit patterns. It often picks fill addresses from lines the bench model knows are outstanding. Directed sequences then line up each collision on purpose.

// File: rtl/pf_filter_pkg.sv
package pf_filter_pkg;
  typedef struct packed {
    logic issue;      // send candidate and record it
    logic fillPass;   // forward a fill
    logic fillClr;    // fill matched, free tracking slot
    logic demClr;     // demand matched shadow, clear prefetch mark
    logic demUseful;  // demand hit an unused prefetched line
  } pfStrobeT;
endpackage

// File: rtl/pf_filter_ctrl.sv
module pf_filter_ctrl
  import pf_filter_pkg::*;
(
  input  logic     candValid,
  input  logic     demValid,
  input  logic     fillValid,
  input  logic     shadowHit,
  input  logic     trackBusy,
  input  logic     fillHit,
  input  logic     demMatch,
  input  logic     demPf,
  output pfStrobeT strb
);
  always_comb begin
    strb           = '0;
    strb.issue     = candValid && !shadowHit && !trackBusy;
    strb.fillPass  = fillValid;
    strb.fillClr   = fillValid && fillHit;
    strb.demClr    = demValid && demMatch;
    strb.demUseful = demValid && demMatch && demPf;
  end
endmodule

// File: rtl/pf_filter_dp.sv
module pf_filter_dp
  import pf_filter_pkg::*;
#(
  parameter int ADDR_W = 48,
  parameter int OFF_W  = 6,
  parameter int IDX_W  = 10,
  parameter int TAG_W  = 6,
  parameter int PC_W   = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              candValid,
  input  logic [ADDR_W-1:0] candAddr,
  input  logic [PC_W-1:0]   candTrigPc,
  input  logic [ADDR_W-1:0] candTrigAddr,
  input  logic              demValid,
  input  logic [ADDR_W-1:0] demAddr,
  input  logic              fillValid,
  input  logic [ADDR_W-1:0] fillAddr,
  input  pfStrobeT          strb,
  output logic              shadowHit,
  output logic              trackBusy,
  output logic              fillHit,
  output logic              demMatch,
  output logic              demPf,
  output logic              reqValid,
  output logic [ADDR_W-1:0] reqAddr,
  output logic              fillOutValid,
  output logic [ADDR_W-1:0] fillOutAddr,
  output logic              fillHasTrig,
  output logic [PC_W-1:0]   fillTrigPc,
  output logic [ADDR_W-1:0] fillTrigAddr
);
  localparam int ENTRIES = 1 << IDX_W;
  localparam int TAG_LO  = OFF_W + IDX_W;
  localparam int LINE_W  = ADDR_W - OFF_W;

  // shadow tag table
  logic [ENTRIES-1:0] shadowValid;
  logic [ENTRIES-1:0] shadowPf;
  logic [TAG_W-1:0]   shadowTag [ENTRIES];
  // tracking table
  logic [ENTRIES-1:0] trackValid;
  logic [LINE_W-1:0]  trackLine [ENTRIES];
  logic [PC_W-1:0]    trackPc   [ENTRIES];
  logic [ADDR_W-1:0]  trackTa   [ENTRIES];

  logic [IDX_W-1:0] candIdx, demIdx, fillIdx;
  logic [TAG_W-1:0] candTag, demTag;
  logic             unusedDemBits;

  assign candIdx = candAddr[OFF_W +: IDX_W];
  assign demIdx  = demAddr[OFF_W +: IDX_W];
  assign fillIdx = fillAddr[OFF_W +: IDX_W];
  assign candTag = candAddr[TAG_LO +: TAG_W];
  assign demTag  = demAddr[TAG_LO +: TAG_W];
  assign unusedDemBits = ^{demAddr[ADDR_W-1:TAG_LO+TAG_W], demAddr[OFF_W-1:0]};

  assign shadowHit = shadowValid[candIdx] && (shadowTag[candIdx] == candTag);
  assign trackBusy = trackValid[candIdx];
  assign fillHit   = trackValid[fillIdx] && (trackLine[fillIdx] == fillAddr[ADDR_W-1:OFF_W]);
  assign demMatch  = shadowValid[demIdx] && (shadowTag[demIdx] == demTag);
  assign demPf     = shadowPf[demIdx];

  // valid and mark bits: demand clear first, issue last so issue wins
  always_ff @(posedge clk) begin
    if (!rstN) begin
      shadowValid <= '0;
      shadowPf    <= '0;
      trackValid  <= '0;
    end else begin
      if (strb.demClr)  shadowPf[demIdx] <= 1'b0;
      if (strb.fillClr) trackValid[fillIdx] <= 1'b0;
      if (strb.issue) begin
        shadowValid[candIdx] <= 1'b1;
        shadowPf[candIdx]    <= 1'b1;
        trackValid[candIdx]  <= 1'b1;
      end
    end
  end

  // payload arrays need no reset
  always_ff @(posedge clk) begin
    if (strb.issue) begin
      shadowTag[candIdx] <= candTag;
      trackLine[candIdx] <= candAddr[ADDR_W-1:OFF_W];
      trackPc[candIdx]   <= candTrigPc;
      trackTa[candIdx]   <= candTrigAddr;
    end
  end

  // registered outputs
  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqValid     <= 1'b0;
      reqAddr      <= '0;
      fillOutValid <= 1'b0;
      fillOutAddr  <= '0;
      fillHasTrig  <= 1'b0;
      fillTrigPc   <= '0;
      fillTrigAddr <= '0;
    end else begin
      reqValid     <= strb.issue;
      if (strb.issue) reqAddr <= candAddr;
      fillOutValid <= strb.fillPass;
      fillOutAddr  <= fillAddr;
      fillHasTrig  <= strb.fillClr;
      fillTrigPc   <= strb.fillClr ? trackPc[fillIdx] : '0;
      fillTrigAddr <= strb.fillClr ? trackTa[fillIdx] : '0;
    end
  end

  a_r3_dup_dropped: assert property (@(posedge clk) disable iff (!rstN)
    candValid && shadowHit |=> !reqValid);
  a_r4_busy_dropped: assert property (@(posedge clk) disable iff (!rstN)
    candValid && trackBusy |=> !reqValid);
  a_r2_no_spurious_req: assert property (@(posedge clk) disable iff (!rstN)
    !candValid |=> !reqValid);
  a_r5_fill_frees_slot: assert property (@(posedge clk) disable iff (!rstN)
    fillValid && fillHit |=> fillHasTrig && !trackValid[$past(fillIdx)]);
  a_r6_nomatch_clean: assert property (@(posedge clk) disable iff (!rstN)
    fillValid && !fillHit |=> fillOutValid && !fillHasTrig && fillTrigPc == '0);
  a_r8_issue_marks: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> shadowValid[reqAddr[OFF_W +: IDX_W]] && shadowPf[reqAddr[OFF_W +: IDX_W]]
                 && trackValid[reqAddr[OFF_W +: IDX_W]]);
endmodule

// File: rtl/pf_filter_tracker.sv
module pf_filter_tracker
  import pf_filter_pkg::*;
#(
  parameter int ADDR_W = 48,
  parameter int OFF_W  = 6,
  parameter int IDX_W  = 10,
  parameter int TAG_W  = 6,
  parameter int PC_W   = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              candValid,
  input  logic [ADDR_W-1:0] candAddr,
  input  logic [PC_W-1:0]   candTrigPc,
  input  logic [ADDR_W-1:0] candTrigAddr,
  input  logic              demValid,
  input  logic [ADDR_W-1:0] demAddr,
  input  logic              fillValid,
  input  logic [ADDR_W-1:0] fillAddr,
  output logic              reqValid,
  output logic [ADDR_W-1:0] reqAddr,
  output logic              fillOutValid,
  output logic [ADDR_W-1:0] fillOutAddr,
  output logic              fillHasTrig,
  output logic [PC_W-1:0]   fillTrigPc,
  output logic [ADDR_W-1:0] fillTrigAddr,
  output logic              demPfHit
);
  pfStrobeT strb;
  logic shadowHit, trackBusy, fillHit, demMatch, demPf;

  pf_filter_ctrl u_ctrl (
    .candValid(candValid), .demValid(demValid), .fillValid(fillValid),
    .shadowHit(shadowHit), .trackBusy(trackBusy), .fillHit(fillHit),
    .demMatch(demMatch), .demPf(demPf), .strb(strb)
  );

  pf_filter_dp #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .TAG_W(TAG_W), .PC_W(PC_W)) u_dp (
    .clk(clk), .rstN(rstN),
    .candValid(candValid), .candAddr(candAddr), .candTrigPc(candTrigPc),
    .candTrigAddr(candTrigAddr), .demValid(demValid), .demAddr(demAddr),
    .fillValid(fillValid), .fillAddr(fillAddr), .strb(strb),
    .shadowHit(shadowHit), .trackBusy(trackBusy), .fillHit(fillHit),
    .demMatch(demMatch), .demPf(demPf),
    .reqValid(reqValid), .reqAddr(reqAddr), .fillOutValid(fillOutValid),
    .fillOutAddr(fillOutAddr), .fillHasTrig(fillHasTrig),
    .fillTrigPc(fillTrigPc), .fillTrigAddr(fillTrigAddr)
  );

  always_ff @(posedge clk) begin
    if (!rstN) demPfHit <= 1'b0;
    else       demPfHit <= strb.demUseful;
  end

  a_r7_useful_needs_demand: assert property (@(posedge clk) disable iff (!rstN)
    !demValid |=> !demPfHit);
endmodule

// File: tb/tb_pf_filter_tracker.sv
`timescale 1ns/1ps
module tb_pf_filter_tracker;
  logic clk = 0, rstN = 0;
  logic candValid = 0, demValid = 0, fillValid = 0;
  logic [47:0] candAddr = 0, candTrigAddr = 0, demAddr = 0, fillAddr = 0;
  logic [5:0] candTrigPc = 0;
  logic reqValid, fillOutValid, fillHasTrig, demPfHit;
  logic [47:0] reqAddr, fillOutAddr, fillTrigAddr;
  logic [5:0] fillTrigPc;

  int nChecks = 0, nFails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pf_filter_tracker dut (.*);

  // bench model
  bit sV [1024]; bit sP [1024]; bit [5:0] sT [1024];
  bit tV [1024]; bit [47:0] tA [1024]; bit [5:0] tPc [1024]; bit [47:0] tTa [1024];

  function automatic bit [9:0] idxOf(bit [47:0] a); return a[15:6]; endfunction
  function automatic bit [5:0] tagOf(bit [47:0] a); return a[21:16]; endfunction

  function automatic bit [47:0] mkAddr(int idx, int tag, bit hi);
    bit [25:0] up = hi ? 26'h2a5 : 26'h013;
    return {up, 6'(tag), 10'(idx), 6'($urandom % 64)};
  endfunction

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step(bit cv, bit [47:0] ca, bit [5:0] cpc, bit [47:0] cta,
                      bit dv, bit [47:0] da, bit fv, bit [47:0] fa, string note);
    bit iss, dup, busy, fh, useful;
    bit [5:0] ePc; bit [47:0] eTa;
    string rq;
    @(negedge clk);
    candValid = cv; candAddr = ca; candTrigPc = cpc; candTrigAddr = cta;
    demValid = dv; demAddr = da; fillValid = fv; fillAddr = fa;
    dup  = sV[idxOf(ca)] && sT[idxOf(ca)] == tagOf(ca);
    busy = tV[idxOf(ca)];
    iss  = cv && !dup && !busy;
    fh   = fv && tV[idxOf(fa)] && tA[idxOf(fa)][47:6] == fa[47:6];
    ePc  = fh ? tPc[idxOf(fa)] : 6'd0;
    eTa  = fh ? tTa[idxOf(fa)] : 48'd0;
    useful = dv && sV[idxOf(da)] && sT[idxOf(da)] == tagOf(da) && sP[idxOf(da)];
    if (dv && sV[idxOf(da)] && sT[idxOf(da)] == tagOf(da)) sP[idxOf(da)] = 0;
    if (fh) tV[idxOf(fa)] = 0;
    if (iss) begin
      sV[idxOf(ca)] = 1; sP[idxOf(ca)] = 1; sT[idxOf(ca)] = tagOf(ca);
      tV[idxOf(ca)] = 1; tA[idxOf(ca)] = ca; tPc[idxOf(ca)] = cpc; tTa[idxOf(ca)] = cta;
    end
    @(posedge clk); #2;
    rq = (note != "") ? note : (iss ? "R2" : (dup ? "R3" : (busy ? "R4" : "R2")));
    chk(reqValid == iss, rq, "reqValid", 64'(reqValid), 64'(iss));
    if (iss) chk(reqAddr == ca, rq, "reqAddr", 64'(reqAddr), 64'(ca));
    rq = fh ? "R5" : "R6";
    chk(fillOutValid == fv, rq, "fillOutValid", 64'(fillOutValid), 64'(fv));
    if (fv) begin
      chk(fillHasTrig == fh, rq, "fillHasTrig", 64'(fillHasTrig), 64'(fh));
      chk(fillOutAddr == fa, rq, "fillOutAddr", 64'(fillOutAddr), 64'(fa));
      chk(fillTrigPc == ePc, rq, "fillTrigPc", 64'(fillTrigPc), 64'(ePc));
      chk(fillTrigAddr == eTa, rq, "fillTrigAddr", 64'(fillTrigAddr), 64'(eTa));
    end
    chk(demPfHit == useful, "R7", "demPfHit", 64'(demPfHit), 64'(useful));
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    bit [47:0] a, b, c, d;
    void'($urandom(32'd1234));
    for (int i = 0; i < 1024; i++) begin sV[i] = 0; sP[i] = 0; tV[i] = 0; end
    repeat (3) @(negedge clk);
    rstN = 1;
    @(posedge clk); #2;
    chk(!reqValid && !fillOutValid && !demPfHit, "R1", "outputs after reset",
        64'({reqValid, fillOutValid, demPfHit}), 64'(0));

    a = mkAddr(3, 1, 0); b = mkAddr(3, 2, 0);
    step(1, a, 6'd5, 48'h1111, 0, 0, 0, 0, "R1");  // first candidate issues
    step(1, a, 6'd5, 48'h1111, 0, 0, 0, 0, "R3");  // duplicate
    step(1, b, 6'd6, 48'h2222, 0, 0, 0, 0, "R4");  // slot busy
    // hi-bit alias fill: same idx/tag, other upper bits -> no trigger
    step(0, 0, 0, 0, 0, 0, 1, {26'h2a5, a[21:0]}, "");
    step(1, b, 6'd6, 48'h2222, 0, 0, 1, a, "R4");  // fill frees slot same cycle, still busy
    step(1, a, 6'd5, 48'h1111, 0, 0, 0, 0, "R9");  // shadow still holds a
    step(0, 0, 0, 0, 1, a, 0, 0, "");              // demand: prefetched line used (R7)
    step(0, 0, 0, 0, 1, a, 0, 0, "");              // second demand: 0 (R7)
    step(1, b, 6'd6, 48'h2222, 0, 0, 0, 0, "R8");  // replaces tag
    step(0, 0, 0, 0, 0, 0, 1, b, "");
    step(1, a, 6'd7, 48'h3333, 0, 0, 0, 0, "R8");  // old tag no longer filters
    step(0, 0, 0, 0, 0, 0, 1, a, "");
    // same-cycle demand to current shadow line and issue to same index
    c = mkAddr(3, 3, 1);
    step(1, c, 6'd9, 48'h4444, 1, a, 0, 0, "R8");
    step(0, 0, 0, 0, 1, c, 1, c, "R8");            // issue mark won: useful
    step(0, 0, 0, 0, 1, mkAddr(9, 0, 0), 0, 0, ""); // absent line (R7)

    for (int n = 0; n < 3000; n++) begin
      bit cv = ($urandom % 3) != 0;
      bit dv = ($urandom % 3) == 0;
      bit fv = ($urandom % 2) == 0;
      int fi = $urandom % 6;
      a = mkAddr($urandom % 6, $urandom % 4, $urandom % 2);
      b = mkAddr($urandom % 6, $urandom % 4, $urandom % 2);
      if (($urandom % 2) && tV[fi]) d = {tA[fi][47:6], 6'($urandom % 64)};
      else d = mkAddr(fi, $urandom % 4, $urandom % 2);
      step(cv, a, 6'($urandom), {16'h0, 32'($urandom)}, dv, b, fv, d, "");
    end
    step(0, 0, 0, 0, 0, 0, 0, 0, "");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule